// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block collects up to 63 active-high interrupt request lines and forwards the single most urgent one to the processor as a three-bit interrupt level together with an eight-bit vector number. Line 0 never raises a request. Its place in the mask is used as a master blocking switch instead. Lines 1 to 7 are meant for external pins, and the remaining lines come from on-chip peripherals. The arbitration treats all 63 lines alike.

Software sets up the controller through a plain register write port with a combinational read-back. Two 32-bit mask words hold one blocking bit per line. Each line also has an 8-bit control register, which gives it an interrupt level and a priority among lines that share that level. Every cycle the block takes the requesting, unmasked and configured line that ranks highest. It registers that line's level and its vector, which is 64 plus the line number. The result appears on the outputs one clock later. A line whose level field is zero is treated as unconfigured and is never forwarded.

Top module: `prio_intc`

## Requirements
- R1: While reset is held and on the first cycle after it, the outputs are level 0 and vector 0. The low mask word reads 0x0000_0001 and the high mask word reads 0xFFFF_FFFF.
- R2: Word address 0 is the mask for lines 0 to 31 and word address 1 is the mask for lines 32 to 63. Line n uses bit n mod 32 of its word. A 1 blocks the line and a 0 lets it through. Both words read back what was written.
- R3: While bit 0 of the low mask word is 1, no line is forwarded, whatever the other mask bits hold.
- R4: Address 64+n holds the 8-bit control register of line n. Bits 5:3 are the level and bits 2:0 are the priority. A write keeps only wdata[7:0], and a read returns the stored byte with bits 31:8 zero.
- R5: Among the lines that are requesting and unmasked, the line with the highest level wins. Among winners of equal level, the line with the highest priority wins.
- R6: A line whose level field is 0 never wins, and neither does a line whose whole control register is 0.
- R7: When two eligible lines carry the same level and priority, the lower-numbered line wins.
- R8: Line 0 is never forwarded, even when its control register and request are set.
- R9: irq_level_o carries the winner's level and irq_vector_o carries 64 plus the winner's line number. When no line is eligible, both outputs are 0.
- R10: A change on the requests or in the registers shows on the outputs after exactly one rising clock edge: the edge that follows a request change, or the edge after the one that performs a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Register address: 0 and 1 for the masks, 64+n for the control register of line n |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq_i | input | 64 | Request lines, bit n is line n (bit 0 is ignored) |
| irq_level_o | output | 3 | Level of the forwarded line, 0 when none |
| irq_vector_o | output | 8 | 64 plus the forwarded line number, 0 when none |

## Verification
The bench builds the block with its default parameters: 64 line slots, 32-bit data words, 3-bit level and priority fields and a vector base of 64. These values put both mask words and the line at each of their edges within reach: line 0, lines 10 and 40 on either side of the word split, and line 63 at the top of the high word. The bench programs colliding level and priority pairs to reach the tie-break. It also programs a level-0 line with a nonzero priority, and it toggles mask-all while requests are pending.

// File: rtl/prio_intc_pkg.sv
// Shared definitions for the masked priority interrupt controller.
// Assumes the line count is a whole multiple of the data word width.
package prio_intc_pkg;

    // Width of one per-line control register.
    localparam int CTRL_W = 8;

    // Field layout inside a control register.
    localparam int PRI_LSB = 0;

endpackage

// File: rtl/prio_intc_regfile.sv
// Register storage: the mask words and one control byte per line.
// Assumes NUM_SRC is a multiple of DATA_W with at least two words, and
// the address has one more bit than the line index. The top bit selects
// the control bank. Reads are combinational.
module prio_intc_regfile #(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    parameter int CTRL_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_SRC-1:0]  mask_vec,
    output logic [CTRL_W-1:0]   ctrl_arr [NUM_SRC]
);
    localparam int MASK_WORDS = NUM_SRC / DATA_W;
    localparam int WSEL_W     = $clog2(MASK_WORDS);
    localparam logic [NUM_SRC-1:0] MASK_RST =
        {{(NUM_SRC-DATA_W){1'b1}}, {(DATA_W-1){1'b0}}, 1'b1};

    logic              sel_ctrl;
    logic              sel_mask;
    logic [IDX_W-1:0]  line_idx;
    logic [WSEL_W-1:0] word_sel;

    // Decode which bank the current address points at.
    always_comb begin
        sel_ctrl = addr[ADDR_W-1];
        line_idx = addr[IDX_W-1:0];
        word_sel = addr[WSEL_W-1:0];
        sel_mask = !addr[ADDR_W-1] && (addr[IDX_W-1:WSEL_W] == '0);
    end

    // Mask words: reset to mask-all, whole-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_vec <= MASK_RST;
        end else if (wr_en && sel_mask) begin
            mask_vec[word_sel*DATA_W +: DATA_W] <= wdata;
        end
    end

    // One control byte per line, cleared to "not configured".
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_arr[gi] <= '0;
            end else if (wr_en && sel_ctrl && (line_idx == IDX_W'(gi))) begin
                ctrl_arr[gi] <= wdata[CTRL_W-1:0];
            end
        end
    end

    // Read-back multiplexer; unmapped addresses read zero.
    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[CTRL_W-1:0] = ctrl_arr[line_idx];
        end else if (sel_mask) begin
            rdata = mask_vec[word_sel*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/prio_intc_arbiter.sv
// Combinational winner selection over all lines.
// Assumes key = {level, priority}, with level in the upper bits. A line
// is eligible when it requests, is unmasked, the master mask (bit 0) is
// clear, it is not line 0 and its level is nonzero. Ties resolve to the
// lowest line number.
module prio_intc_arbiter #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    parameter int PRI_W   = 3,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int KEY_W  = LVL_W + PRI_W
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] mask_vec,
    input  logic [KEY_W-1:0]   key_arr [NUM_SRC],
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output logic [LVL_W-1:0]   win_lvl
);
    logic [NUM_SRC-1:0] elig;
    logic [KEY_W-1:0]   best_key;

    // Per-line eligibility; line 0 is reserved as the master mask slot.
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_elig
        if (gi == 0) begin : g_rsv
            assign elig[gi] = 1'b0;
        end else begin : g_line
            assign elig[gi] = req[gi] && !mask_vec[gi] && !mask_vec[0]
                              && (key_arr[gi][KEY_W-1:PRI_W] != '0);
        end
    end

    // Scan upward, replacing the holder only on a strictly larger key.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_key  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!win_valid || key_arr[i] > best_key)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best_key  = key_arr[i];
            end
        end
        win_lvl = best_key[KEY_W-1:PRI_W];
    end

endmodule

// File: rtl/prio_intc.sv
// Masked priority interrupt controller top level.
// Holds the register file and the arbiter, and registers the forwarded
// level and vector. Assumes VEC_BASE + NUM_SRC - 1 fits in VEC_W bits.
module prio_intc #(
    parameter int NUM_SRC  = 64,
    parameter int DATA_W   = 32,
    parameter int LVL_W    = 3,
    parameter int PRI_W    = 3,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int ADDR_W  = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [NUM_SRC-1:0]  irq_i,
    output logic [LVL_W-1:0]    irq_level_o,
    output logic [VEC_W-1:0]    irq_vector_o
);
    import prio_intc_pkg::*;

    localparam int KEY_W = LVL_W + PRI_W;

    logic [NUM_SRC-1:0] mask_vec;
    logic [CTRL_W-1:0]  ctrl_arr [NUM_SRC];
    logic [KEY_W-1:0]   key_arr  [NUM_SRC];
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_lvl;

    prio_intc_regfile #(
        .NUM_SRC(NUM_SRC),
        .DATA_W (DATA_W),
        .CTRL_W (CTRL_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .mask_vec(mask_vec),
        .ctrl_arr(ctrl_arr)
    );

    // Extract the level/priority key from each control byte.
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_key
        assign key_arr[gi] = ctrl_arr[gi][PRI_LSB +: KEY_W];
    end

    prio_intc_arbiter #(
        .NUM_SRC(NUM_SRC),
        .LVL_W  (LVL_W),
        .PRI_W  (PRI_W)
    ) u_arb (
        .req      (irq_i),
        .mask_vec (mask_vec),
        .key_arr  (key_arr),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .win_lvl  (win_lvl)
    );

    // Register the forwarded level and vector; zero when nothing wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level_o  <= '0;
            irq_vector_o <= '0;
        end else if (win_valid) begin
            irq_level_o  <= win_lvl;
            irq_vector_o <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        end else begin
            irq_level_o  <= '0;
            irq_vector_o <= '0;
        end
    end

endmodule

// File: rtl/prio_intc_chk.sv
// Property checker for prio_intc, attached by bind below.
// Observes the ports and the live mask vector.
module prio_intc_chk #(
    parameter int NUM_SRC  = 64,
    parameter int LVL_W    = 3,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_i,
    input logic [NUM_SRC-1:0] mask_vec,
    input logic [LVL_W-1:0]   irq_level_o,
    input logic [VEC_W-1:0]   irq_vector_o
);
    logic [NUM_SRC-1:0] irq_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [IDX_W-1:0]   out_idx;

    // Hold last cycle's inputs, which the registered outputs reflect.
    always_ff @(posedge clk) begin
        irq_q  <= irq_i;
        mask_q <= mask_vec;
    end

    assign out_idx = IDX_W'(irq_vector_o - VEC_W'(VEC_BASE));

    // R1: outputs are cleared on the first cycle after reset.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_level_o == '0 && irq_vector_o == '0));

    // R3: master mask set last cycle means nothing is forwarded now.
    a_r3_mask_all_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_vec[0]) |-> irq_level_o == '0);

    // R9: no winner means a zero vector.
    a_r9_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level_o == '0 |-> irq_vector_o == '0);

    // R8: the reserved line 0 vector never appears.
    a_r8_line0_never: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level_o != '0 |-> irq_vector_o != VEC_W'(VEC_BASE));

    // R5: the forwarded line was requesting and unmasked one cycle earlier.
    a_r5_winner_pending_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level_o != '0 |-> (irq_q[out_idx] && !mask_q[out_idx]));

endmodule

bind prio_intc prio_intc_chk #(
    .NUM_SRC (NUM_SRC),
    .LVL_W   (LVL_W),
    .VEC_W   (VEC_W),
    .VEC_BASE(VEC_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_i       (irq_i),
    .mask_vec    (mask_vec),
    .irq_level_o (irq_level_o),
    .irq_vector_o(irq_vector_o)
);

// File: tb/prio_intc_tb.sv
// Scoreboard bench: the driver queues expected outputs, the monitor
// compares them at the falling edge after the output register updates.
module prio_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] irq_i = '0;
    logic [2:0]  irq_level_o;
    logic [7:0]  irq_vector_o;

    int n_checks = 0;
    int n_fails  = 0;

    logic [2:0] q_lvl [$];
    logic [7:0] q_vec [$];
    string      q_tag [$];

    prio_intc u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .irq_i       (irq_i),
        .irq_level_o (irq_level_o),
        .irq_vector_o(irq_vector_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Monitor: pop one expected item per falling edge and compare it.
    always @(negedge clk) begin
        if (q_lvl.size() > 0) begin
            logic [2:0] el;
            logic [7:0] ev;
            string      et;
            el = q_lvl.pop_front();
            ev = q_vec.pop_front();
            et = q_tag.pop_front();
            n_checks++;
            if (irq_level_o !== el || irq_vector_o !== ev) begin
                n_fails++;
                $display("FAIL %s: level/vector got %0d/%0d expected %0d/%0d",
                         et, irq_level_o, irq_vector_o, el, ev);
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Queue the expectation after the next rising edge, then let the monitor compare.
    task automatic expect_out(input logic [2:0] l, input logic [7:0] v, input string tag);
        @(posedge clk);
        q_lvl.push_back(l); q_vec.push_back(v); q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic check_rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        n_checks++;
        if (rdata !== exp) begin
            n_fails++;
            $display("FAIL %s: rdata[%0d] got %h expected %h", tag, a, rdata, exp);
        end
    endtask

    task automatic set_irq(input logic [63:0] v);
        irq_i = v;
    endtask

    localparam logic [6:0] CB = 7'd64;   // control bank base

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R1: reset state while and after reset
        expect_out(3'd0, 8'd0, "R1 during reset");
        rst_n = 1'b1;
        expect_out(3'd0, 8'd0, "R1 after reset");
        check_rd(7'd0, 32'h0000_0001, "R1 low mask reset");
        check_rd(7'd1, 32'hFFFF_FFFF, "R1 high mask reset");

        // Configure lines
        wr(CB + 7'd3,  32'h11);   // level 2 prio 1
        wr(CB + 7'd40, 32'h2B);   // level 5 prio 3
        wr(CB + 7'd10, 32'h2E);   // level 5 prio 6
        wr(CB + 7'd21, 32'hFFFF_FF05);  // level 0 prio 5, junk upper bits
        wr(CB + 7'd50, 32'h2E);   // same key as line 10
        wr(CB + 7'd63, 32'h3F);   // level 7 prio 7
        wr(CB + 7'd0,  32'h3F);   // reserved line
        check_rd(CB + 7'd40, 32'h0000_002B, "R4 control readback");
        check_rd(CB + 7'd21, 32'h0000_0005, "R4 upper bits dropped");

        // R3: mask-all from reset blocks a pending line
        set_irq(64'h8);
        expect_out(3'd0, 8'd0, "R3 mask-all after reset");
        wr(7'd0, 32'h0);
        wr(7'd1, 32'h0);
        expect_out(3'd2, 8'd67, "R9 single line 3");
        wr(7'd0, 32'h1);
        expect_out(3'd0, 8'd0, "R3 mask-all set");
        check_rd(7'd0, 32'h1, "R2 low mask readback");
        wr(7'd0, 32'h0);

        // R5: level then priority
        set_irq((64'h1 << 3) | (64'h1 << 40));
        expect_out(3'd5, 8'd104, "R5 higher level wins");
        set_irq((64'h1 << 3) | (64'h1 << 40) | (64'h1 << 10));
        expect_out(3'd5, 8'd74, "R5 higher priority wins");

        // R2: mask bits in both words
        wr(7'd0, 32'h1 << 10);
        expect_out(3'd5, 8'd104, "R2 low mask bit 10");
        wr(7'd1, 32'h1 << 8);
        expect_out(3'd2, 8'd67, "R2 high mask bit 8 (line 40)");
        check_rd(7'd1, 32'h0000_0100, "R2 high mask readback");
        wr(7'd0, 32'h0);
        wr(7'd1, 32'h0);

        // R6: unconfigured and level-0 lines
        set_irq(64'h1 << 20);
        expect_out(3'd0, 8'd0, "R6 zero control");
        set_irq(64'h1 << 21);
        expect_out(3'd0, 8'd0, "R6 level field zero");

        // R7: tie goes to the lower line
        set_irq((64'h1 << 10) | (64'h1 << 50));
        expect_out(3'd5, 8'd74, "R7 tie lower index");
        set_irq(64'h1 << 50);
        expect_out(3'd5, 8'd114, "R7 line 50 alone");

        // R8: line 0 ignored
        set_irq(64'h1);
        expect_out(3'd0, 8'd0, "R8 line 0 alone");
        set_irq(64'h1 | (64'h1 << 3));
        expect_out(3'd2, 8'd67, "R8 line 0 with line 3");

        // R9: top line
        set_irq(64'h1 << 63);
        expect_out(3'd7, 8'd127, "R9 line 63");
        wr(7'd1, 32'h8000_0000);
        expect_out(3'd0, 8'd0, "R2 high mask bit 31");

        // R10: one-edge latency
        set_irq(64'h0);
        expect_out(3'd0, 8'd0, "R10 idle");
        set_irq(64'h8);
        #1;
        n_checks++;
        if (irq_level_o !== 3'd0) begin
            n_fails++;
            $display("FAIL R10 before edge: level got %0d expected 0", irq_level_o);
        end
        expect_out(3'd2, 8'd67, "R10 after one edge");
        set_irq(64'h0);
        expect_out(3'd0, 8'd0, "R10 release after one edge");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule